// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Core with Update Freeze

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours (24-hour), day of the week, date, month and a two-digit year. A free-running set of internal counters advances once per pulse of a one-second enable. Software reaches the time through a small byte-wide register file. What it reads and writes is a set of visible holding registers, kept apart from the counters.

A control register carries two freeze bits. While either one is set, the visible registers stop following the counters, and the counters keep running. The read freeze lets software read several fields without tearing. The write freeze opens the time fields for writing. When it is cleared, the written values are loaded into the counters in one cycle. A stop bit kept in the seconds register halts the counters. It comes out of reset set, so time does not advance until software clears it.

Register map, by address: 0 is control (bit 7 write freeze, bit 6 read freeze, other bits read 0); 1 is seconds (bit 7 stop, bits 6:0 BCD); 2 is minutes (6:0); 3 is hours (5:0); 4 is day of week (2:0, counts 1 to 7); 5 is date (5:0); 6 is month (4:0); 7 is year (7:0). Bits outside a field read as 0.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, control reads 0x00, seconds reads 0x80 (stop set, 00 seconds), minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R2: While the stop bit (seconds bit 7) is 1, tick pulses do not advance the time. A write to address 1 updates the stop bit whether or not a freeze bit is set. Once the stop bit is 0, every tick advances the time by one second.
- R3: Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00 and advance the day of week, which wraps from 0x07 to 0x01.
- R4: An hour wrap advances the date. The date wraps to 0x01 past the month's length (0x30 for April, June, September and November, 0x31 for the other months except February) and advances the month. The month wraps from 0x12 to 0x01 and advances the year, which wraps from 0x99 to 0x00.
- R5: With LEAP_EN set, February has 29 days when the two-digit year is a multiple of 4 (including 00), and 28 days otherwise.
- R6: With both freeze bits clear, each tick copies the advanced counter value into the visible registers in the same clock edge. Between ticks the visible registers do not change.
- R7: While the read freeze (control bit 6) is set, the visible time stays unchanged and the counters keep counting ticks. After the bit is cleared, the next tick shows the advanced count.
- R8: A bus write to a time field (addresses 1 to 7, seconds bits 6:0) takes effect only while the write freeze (control bit 7) is set. Otherwise the field is unchanged.
- R9: Writing control with bit 7 at 0 while the write freeze is set loads the visible time into the counters. Ticks received during the freeze are discarded, and counting continues from the written values.
- R10: The read data is a combinational function of the address. Control returns the two freeze bits in bits 7 and 6 and zeros below them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sec_tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |

## Verification
The assertions assume the tick is a single-cycle pulse. They also assume that a value loaded into the counters has a seconds field below 0x80, which the field masking on writes guarantees. The stability checks assume the only things that change the visible registers are a tick with no freeze set or a bus write. The bench therefore drives writes and ticks in separate cycles, always at the falling clock edge, and writes only valid BCD. This keeps every rollover, and its expected result, well defined.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef struct packed {
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   localparam int unsigned A_CTRL  = 0;
   localparam int unsigned A_SEC   = 1;
   localparam int unsigned A_MIN   = 2;
   localparam int unsigned A_HOUR  = 3;
   localparam int unsigned A_DOW   = 4;
   localparam int unsigned A_DATE  = 5;
   localparam int unsigned A_MONTH = 6;
   localparam int unsigned A_YEAR  = 7;

   localparam rtc_time_t TIME_RST = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                      dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

   function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
      return 8'(b[7:4] * 4'd10) + 8'(b[3:0]);
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] month, input logic leap);
      logic [7:0] m;
      m = bcd_to_bin(month);
      case (m)
         8'd2:                     month_len = leap ? 8'h29 : 8'h28;
         8'd4, 8'd6, 8'd9, 8'd11:  month_len = 8'h30;
         default:                  month_len = 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step (
   input  logic [7:0] val_i,
   input  logic       en_i,
   input  logic [7:0] lo_i,
   input  logic [7:0] hi_i,
   output logic [7:0] nxt_o,
   output logic       wrap_o
);
   logic [7:0] inc;

   always_comb begin
      if (val_i[3:0] >= 4'd9) inc = {val_i[7:4] + 4'd1, 4'd0};
      else                    inc = {val_i[7:4], val_i[3:0] + 4'd1};
      wrap_o = en_i && (val_i >= hi_i);
      if (wrap_o)    nxt_o = lo_i;
      else if (en_i) nxt_o = inc;
      else           nxt_o = val_i;
   end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
   import rtc_pkg::*;
#(
   parameter bit LEAP_EN = 1'b1
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      tick_i,
   input  logic      run_i,
   input  logic      load_i,
   input  rtc_time_t load_val_i,
   output rtc_time_t time_o,
   output rtc_time_t next_o
);
   rtc_time_t time_q;
   logic      step;
   logic      c_sec, c_min, c_hour, c_dow, c_date, c_month, c_year;
   logic      leap;
   logic [7:0] date_hi;

   assign step = tick_i && run_i;

   generate
      if (LEAP_EN) begin : g_leap
         assign leap = (bcd_to_bin(time_q.year) & 8'd3) == 8'd0;
      end else begin : g_noleap
         assign leap = 1'b0;
      end
   endgenerate

   assign date_hi = month_len(time_q.month, leap);

   rtc_bcd_step u_sec   (.val_i(time_q.sec),   .en_i(step),   .lo_i(8'h00), .hi_i(8'h59),
                         .nxt_o(next_o.sec),   .wrap_o(c_sec));
   rtc_bcd_step u_min   (.val_i(time_q.min),   .en_i(c_sec),  .lo_i(8'h00), .hi_i(8'h59),
                         .nxt_o(next_o.min),   .wrap_o(c_min));
   rtc_bcd_step u_hour  (.val_i(time_q.hour),  .en_i(c_min),  .lo_i(8'h00), .hi_i(8'h23),
                         .nxt_o(next_o.hour),  .wrap_o(c_hour));
   rtc_bcd_step u_dow   (.val_i(time_q.dow),   .en_i(c_hour), .lo_i(8'h01), .hi_i(8'h07),
                         .nxt_o(next_o.dow),   .wrap_o(c_dow));
   rtc_bcd_step u_date  (.val_i(time_q.date),  .en_i(c_hour), .lo_i(8'h01), .hi_i(date_hi),
                         .nxt_o(next_o.date),  .wrap_o(c_date));
   rtc_bcd_step u_month (.val_i(time_q.month), .en_i(c_date), .lo_i(8'h01), .hi_i(8'h12),
                         .nxt_o(next_o.month), .wrap_o(c_month));
   rtc_bcd_step u_year  (.val_i(time_q.year),  .en_i(c_month),.lo_i(8'h00), .hi_i(8'h99),
                         .nxt_o(next_o.year),  .wrap_o(c_year));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     time_q <= TIME_RST;
      else if (load_i) time_q <= load_val_i;
      else if (step)   time_q <= next_o;
   end

   assign time_o = time_q;

   // R2
   hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step && !load_i) |=> $stable(time_q));
   // R3
   sec_advances_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step && !load_i && time_q.sec < 8'h80) |=> time_q.sec != $past(time_q.sec));
   // R3
   dow_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step && !load_i && $past(time_q.dow) == 8'h07 && time_q.dow == 8'h07 && c_hour)
         |=> time_q.dow == 8'h01);
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 8,
   parameter bit          LEAP_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sec_tick_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o
);
   localparam int unsigned NUM_REGS = 8;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("bcd_rtc_core: DATA_W must be 8");
      end
      if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
         $error("bcd_rtc_core: ADDR_W too small for the register map");
      end
   endgenerate

   logic      wfrz_q, rfrz_q, stop_q;
   rtc_time_t vis_q, cnt_time, cnt_next;
   logic      wr_ctrl, release_w;

   assign wr_ctrl   = we_i && (addr_i == ADDR_W'(A_CTRL));
   assign release_w = wr_ctrl && wfrz_q && !wdata_i[7];

   rtc_counter #(.LEAP_EN(LEAP_EN)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (sec_tick_i),
      .run_i     (!stop_q),
      .load_i    (release_w),
      .load_val_i(vis_q),
      .time_o    (cnt_time),
      .next_o    (cnt_next)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wfrz_q <= 1'b0;
         rfrz_q <= 1'b0;
         stop_q <= 1'b1;
         vis_q  <= TIME_RST;
      end else begin
         if (wr_ctrl) {wfrz_q, rfrz_q} <= wdata_i[7:6];
         if (we_i && addr_i == ADDR_W'(A_SEC)) stop_q <= wdata_i[7];
         if (wfrz_q) begin
            if (we_i) begin
               case (int'(addr_i))
                  A_SEC:   vis_q.sec   <= {1'b0, wdata_i[6:0]};
                  A_MIN:   vis_q.min   <= {1'b0, wdata_i[6:0]};
                  A_HOUR:  vis_q.hour  <= {2'b0, wdata_i[5:0]};
                  A_DOW:   vis_q.dow   <= {5'b0, wdata_i[2:0]};
                  A_DATE:  vis_q.date  <= {2'b0, wdata_i[5:0]};
                  A_MONTH: vis_q.month <= {3'b0, wdata_i[4:0]};
                  A_YEAR:  vis_q.year  <= wdata_i;
                  default: ;
               endcase
            end
         end else if (!rfrz_q && sec_tick_i) begin
            vis_q <= cnt_next;
         end
      end
   end

   always_comb begin
      case (int'(addr_i))
         A_CTRL:  rdata_o = {wfrz_q, rfrz_q, 6'b0};
         A_SEC:   rdata_o = {stop_q, vis_q.sec[6:0]};
         A_MIN:   rdata_o = vis_q.min;
         A_HOUR:  rdata_o = vis_q.hour;
         A_DOW:   rdata_o = vis_q.dow;
         A_DATE:  rdata_o = vis_q.date;
         A_MONTH: rdata_o = vis_q.month;
         A_YEAR:  rdata_o = vis_q.year;
         default: rdata_o = 8'h00;
      endcase
   end

   // R7
   frozen_vis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((wfrz_q || rfrz_q) && !we_i) |=> $stable(vis_q));
   // R8
   ignored_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wfrz_q && we_i && addr_i != ADDR_W'(A_CTRL) && !sec_tick_i) |=> $stable(vis_q));
   // R9
   release_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      release_w |=> cnt_time == $past(vis_q));
   // R6
   refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wfrz_q && !rfrz_q && sec_tick_i && !we_i) |=> vis_q == cnt_time);
endmodule

// File: tb/test_bcd_rtc_core.sv
module test_bcd_rtc_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [2:0] addr = '0;
   logic       we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   bcd_rtc_core i_bcd_rtc_core (
      .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(tick),
      .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata)
   );

   task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      addr = a;
      #1;
      n_chk++;
      if (rdata !== exp) begin
         n_fail++;
         $display("FAIL %s addr %0d: got %h expected %h", req, a, rdata, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
      wr(0, 8'h80);
      wr(1, s); wr(2, mi); wr(3, h); wr(4, dw); wr(5, dt); wr(6, mo); wr(7, y);
      wr(0, 8'h00);
   endtask

   task automatic t_reset;
      chk(0, 8'h00, "R1"); chk(1, 8'h80, "R1"); chk(2, 8'h00, "R1");
      chk(3, 8'h00, "R1"); chk(4, 8'h01, "R1"); chk(5, 8'h01, "R1");
      chk(6, 8'h01, "R1"); chk(7, 8'h00, "R1");
   endtask

   task automatic t_stop;
      tk(2);
      chk(1, 8'h80, "R2 stopped");
      wr(1, 8'h00);
      chk(1, 8'h00, "R2 stop cleared");
      tk(1);
      chk(1, 8'h01, "R2 running");
      chk(1, 8'h01, "R6 stable between ticks");
      wr(1, 8'h80);
      tk(3);
      chk(1, 8'h81, "R2 stopped again");
      wr(1, 8'h00);
   endtask

   task automatic t_time_roll;
      set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h01, 8'h01, 8'h00);
      tk(1);
      chk(1, 8'h00, "R3 sec"); chk(2, 8'h00, "R3 min"); chk(3, 8'h00, "R3 hour");
      chk(4, 8'h01, "R3 dow"); chk(5, 8'h02, "R4 date");
      set_time(8'h58, 8'h09, 8'h05, 8'h03, 8'h10, 8'h06, 8'h20);
      tk(2);
      chk(1, 8'h00, "R3 sec carry"); chk(2, 8'h10, "R3 min bcd carry");
   endtask

   task automatic t_cal_roll;
      set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h15);
      tk(1);
      chk(5, 8'h01, "R4 april end"); chk(6, 8'h05, "R4 month");
      set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h15);
      tk(1);
      chk(5, 8'h31, "R4 may 31");
      set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
      tk(1);
      chk(5, 8'h01, "R4 new year date"); chk(6, 8'h01, "R4 new year month");
      chk(7, 8'h00, "R4 year wrap");
   endtask

   task automatic t_leap;
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
      tk(1);
      chk(5, 8'h29, "R5 leap 24"); chk(6, 8'h02, "R5 leap month");
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
      tk(1);
      chk(5, 8'h01, "R5 common 23"); chk(6, 8'h03, "R5 common month");
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h00);
      tk(1);
      chk(5, 8'h01, "R5 leap 00 end"); chk(6, 8'h03, "R5 leap 00 month");
   endtask

   task automatic t_read_freeze;
      set_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h01);
      wr(0, 8'h40);
      chk(0, 8'h40, "R10 read bit");
      tk(3);
      chk(1, 8'h00, "R7 frozen");
      wr(0, 8'h00);
      chk(1, 8'h00, "R7 stale until tick");
      tk(1);
      chk(1, 8'h04, "R7 counters ran");
   endtask

   task automatic t_write;
      set_time(8'h00, 8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h01);
      wr(2, 8'h33);
      chk(2, 8'h20, "R8 ignored write");
      wr(0, 8'h80);
      wr(2, 8'h45);
      tk(5);
      chk(2, 8'h45, "R8 accepted write");
      chk(1, 8'h00, "R9 frozen during write");
      wr(0, 8'h00);
      tk(1);
      chk(1, 8'h01, "R9 loaded sec"); chk(2, 8'h45, "R9 loaded min");
      wr(0, 8'hFF);
      chk(0, 8'hC0, "R10 ctrl bits");
      wr(0, 8'h00);
      chk(0, 8'h00, "R10 ctrl clear");
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_stop;
      t_time_roll;
      t_cal_roll;
      t_leap;
      t_read_freeze;
      t_write;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule